// File: doc/BRIEF.md
# I2C register byte-access sequencer

This block runs one complete register-byte transaction against an I2C target, with no software in the loop. It does this by issuing reads and writes to the register port of an existing byte-level I2C master controller. A client supplies the direction, a 7-bit target address, an 8-bit register index and, for writes, one data byte. The sequencer then steps the controller through the START, address, index and data phases. After every phase it compares the controller's status code against the value that phase should produce.

Every wait for the controller is bounded by a poll budget. Any wrong status or exhausted budget abandons the transfer. Whatever the outcome, the sequencer closes the bus with a STOP. It then confirms the bus has settled through three ordered checks before it pulses done with a pass flag, a separate bus-stuck flag and, for reads, the received byte.

The controller register port carries one access per cycle. Read data returns combinationally in the same cycle. The selects are: 0 control, 1 data, 2 status, 3 line state.

Top module: `i2c_regseq`

## Requirements
- R1: Reset behaviour. While reset is held and afterwards, cmd_ready_o is 1, done_o is 0, reg_req_o is 0, and pass_o and bus_stuck_o are 0.
- R2: Command acceptance and latching.
  - A command is taken only in a cycle where cmd_valid_i and cmd_ready_o are both high. cmd_ready_o then drops until the transfer ends.
  - cmd_valid_i while busy has no effect.
  - The command fields are latched at acceptance, so later input changes do not alter the transfer.
- R3: Idle check at start. First the sequencer reads control, then status. If status is not 0xF8, no bus phase is issued, the transfer goes straight to STOP, and it ends with pass_o = 0.
- R4: Write transfer. The order is START (status 0x08), target address with direction 0 (0x18), register index (0x28), then the data byte (0x28). Each phase's byte is loaded into the data register before the control write that launches it.
- R5: Read transfer. The order is START (0x08), address with direction 0 (0x18), register index (0x28), repeated START (0x10), address with direction 1 (0x40), then one received byte (0x58). The byte is taken from the data register before the status check and is reported on rdata_o.
- R6: Address byte. It is {address[6:0], dir}, with dir = 0 for the write-direction phases and 1 for the read phase.
- R7: Control writes. Control bit 5 launches START, bit 4 requests STOP, and bit 3 is the write-one-to-clear interrupt flag. Bits 7:6 of every control write repeat the values read from control at the start of the transfer. The launch values in bits 5:0 are:
  - START: 0x20.
  - Repeated START: 0x28.
  - Other phases: 0x08.
- R8: Flag wait bound. Each wait for the interrupt flag reads control at most 767 (0x2FF) times in a row. If the flag is still clear after that, the transfer fails.
- R9: STOP on every exit. Every transfer, passed or failed, issues exactly one control write with bits 5:0 = 0x18 (STOP plus flag clear).
- R10: STOP completion. After the STOP write, three polls run in order: control bit 4 reads 0, status reads 0xF8, and line state reads 0x3A. Each poll has its own 767-read budget. An exhausted budget sets bus_stuck_o and leaves pass_o as the transfer phases set it.
- R11: Done and results. done_o is a one-cycle pulse followed by cmd_ready_o. pass_o, bus_stuck_o and rdata_o are valid with done_o and hold until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_read_i | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_dev_i | input | 7 | Target device address |
| cmd_reg_i | input | 8 | Register index inside the target |
| cmd_wdata_i | input | 8 | Byte to write |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| pass_o | output | 1 | Transfer phases all matched |
| bus_stuck_o | output | 1 | STOP completion poll ran out of budget |
| rdata_o | output | 8 | Received byte (read transfers) |
| reg_req_o | output | 1 | Controller register access this cycle |
| reg_we_o | output | 1 | 1 = write access, 0 = read access |
| reg_addr_o | output | 2 | Controller register select |
| reg_wdata_o | output | 8 | Controller write data |
| reg_rdata_i | input | 8 | Controller read data, same cycle |

## Verification
The controller register port is due one cycle after the state that requests it. A control write therefore appears on the clock after the preceding status match or data load. Each STOP poll decides in the same cycle as its read.

Because the number of polls depends on when the controller model raises its flag, the bench does not tie writes to fixed cycles. Instead, every clock it compares each controller write against the next entry of an expected write list, so order and values are exact whatever the timing. It counts consecutive polls to confirm the 767-read budgets. pass_o, bus_stuck_o and rdata_o are sampled on the falling edge within the done_o cycle.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_LINE = 2'd3
  } rsel_e;

  // byte loaded into the data register before a phase is launched
  typedef enum logic [2:0] {
    LD_NONE,
    LD_DEVW,
    LD_DEVR,
    LD_REG,
    LD_WDATA
  } ld_e;

  localparam logic [7:0] ST_IDLE    = 8'hF8;
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_RX_DONE = 8'h58;
  localparam logic [7:0] LINE_FREE  = 8'h3A;

  localparam int CB_START = 5;
  localparam int CB_STOP  = 4;
  localparam int CB_FLAG  = 3;

  localparam logic [5:0] KICK_START  = 6'h20;
  localparam logic [5:0] KICK_RSTART = 6'h28;
  localparam logic [5:0] KICK_NEXT   = 6'h08;
  localparam logic [5:0] KICK_STOP   = 6'h18;

  typedef struct packed {
    ld_e        ld;
    logic [5:0] kick;
    logic [7:0] code;
    logic       recv;
    logic       last;
  } step_t;

endpackage

// File: rtl/i2cseq_step_tbl.sv
module i2cseq_step_tbl
  import i2cseq_pkg::*;
#(
  parameter int unsigned STEP_W = 3
) (
  input  logic              rd_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);

  always_comb begin
    step_o = '{ld: LD_NONE, kick: KICK_NEXT, code: ST_RX_DONE, recv: 1'b0, last: 1'b1};
    unique case (idx_i)
      3'd0: step_o = '{ld: LD_NONE, kick: KICK_START, code: ST_START,  recv: 1'b0, last: 1'b0};
      3'd1: step_o = '{ld: LD_DEVW, kick: KICK_NEXT,  code: ST_AW_ACK, recv: 1'b0, last: 1'b0};
      3'd2: step_o = '{ld: LD_REG,  kick: KICK_NEXT,  code: ST_TX_ACK, recv: 1'b0, last: 1'b0};
      3'd3: begin
        if (rd_i) step_o = '{ld: LD_NONE,  kick: KICK_RSTART, code: ST_RSTART, recv: 1'b0, last: 1'b0};
        else      step_o = '{ld: LD_WDATA, kick: KICK_NEXT,   code: ST_TX_ACK, recv: 1'b0, last: 1'b1};
      end
      3'd4: step_o = '{ld: LD_DEVR, kick: KICK_NEXT, code: ST_AR_ACK,  recv: 1'b0, last: 1'b0};
      3'd5: step_o = '{ld: LD_NONE, kick: KICK_NEXT, code: ST_RX_DONE, recv: 1'b1, last: 1'b1};
      default: ;
    endcase
  end

endmodule

// File: rtl/i2cseq_poll_cnt.sv
module i2cseq_poll_cnt #(
  parameter int unsigned LIMIT = 'h2FF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // expires on the LIMIT-th unsuccessful poll
  assign expire_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
  import i2cseq_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 'h2FF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic       cmd_read_i,
  input  logic [6:0] cmd_dev_i,
  input  logic [7:0] cmd_reg_i,
  input  logic [7:0] cmd_wdata_i,
  output logic       done_o,
  output logic       pass_o,
  output logic       bus_stuck_o,
  output logic [7:0] rdata_o,
  output logic       reg_req_o,
  output logic       reg_we_o,
  output logic [1:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);

  localparam int unsigned STEP_W = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_GETCTL, S_CHKIDLE, S_ISSUE, S_KICK, S_WAIT, S_RXDATA,
    S_CHECK, S_STOP, S_P_STOP, S_P_IDLE, S_P_LINE, S_DONE
  } state_e;

  state_e state_q, state_n;

  logic              rd_q;
  logic [6:0]        dev_q;
  logic [7:0]        reg_q;
  logic [7:0]        wd_q;
  logic [1:0]        keep_q;
  logic [STEP_W-1:0] step_q;
  logic              pass_q, stuck_q;
  logic [7:0]        rx_q;

  step_t step;
  logic  poll_st, cond_met, tick, expire, clr;
  logic  [7:0] ld_byte;

  i2cseq_step_tbl #(.STEP_W(STEP_W)) u_tbl (
    .rd_i   (rd_q),
    .idx_i  (step_q),
    .step_o (step)
  );

  i2cseq_poll_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .tick_i   (tick),
    .expire_o (expire)
  );

  always_comb begin
    unique case (step.ld)
      LD_DEVW:  ld_byte = {dev_q, 1'b0};
      LD_DEVR:  ld_byte = {dev_q, 1'b1};
      LD_REG:   ld_byte = reg_q;
      LD_WDATA: ld_byte = wd_q;
      default:  ld_byte = 8'h00;
    endcase
  end

  assign poll_st = (state_q == S_WAIT) || (state_q == S_P_STOP) ||
                   (state_q == S_P_IDLE) || (state_q == S_P_LINE);

  always_comb begin
    unique case (state_q)
      S_WAIT:   cond_met = reg_rdata_i[CB_FLAG];
      S_P_STOP: cond_met = !reg_rdata_i[CB_STOP];
      S_P_IDLE: cond_met = (reg_rdata_i == ST_IDLE);
      S_P_LINE: cond_met = (reg_rdata_i == LINE_FREE);
      default:  cond_met = 1'b0;
    endcase
  end

  assign tick = poll_st && !cond_met;
  assign clr  = (state_n != state_q);

  // register port drive
  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = RSEL_CTRL;
    reg_wdata_o = 8'h00;
    unique case (state_q)
      S_GETCTL: begin reg_req_o = 1'b1; reg_addr_o = RSEL_CTRL; end
      S_CHKIDLE, S_CHECK, S_P_IDLE: begin reg_req_o = 1'b1; reg_addr_o = RSEL_STAT; end
      S_WAIT, S_P_STOP: begin reg_req_o = 1'b1; reg_addr_o = RSEL_CTRL; end
      S_RXDATA: begin reg_req_o = 1'b1; reg_addr_o = RSEL_DATA; end
      S_P_LINE: begin reg_req_o = 1'b1; reg_addr_o = RSEL_LINE; end
      S_ISSUE: begin
        reg_req_o = 1'b1;
        reg_we_o  = 1'b1;
        if (step.ld != LD_NONE) begin
          reg_addr_o  = RSEL_DATA;
          reg_wdata_o = ld_byte;
        end else begin
          reg_addr_o  = RSEL_CTRL;
          reg_wdata_o = {keep_q, step.kick};
        end
      end
      S_KICK: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = RSEL_CTRL;
        reg_wdata_o = {keep_q, step.kick};
      end
      S_STOP: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = RSEL_CTRL;
        reg_wdata_o = {keep_q, KICK_STOP};
      end
      default: ;
    endcase
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      S_IDLE:    if (cmd_valid_i) state_n = S_GETCTL;
      S_GETCTL:  state_n = S_CHKIDLE;
      S_CHKIDLE: state_n = (reg_rdata_i == ST_IDLE) ? S_ISSUE : S_STOP;
      S_ISSUE:   state_n = (step.ld != LD_NONE) ? S_KICK : S_WAIT;
      S_KICK:    state_n = S_WAIT;
      S_WAIT: begin
        if (cond_met)    state_n = step.recv ? S_RXDATA : S_CHECK;
        else if (expire) state_n = S_STOP;
      end
      S_RXDATA:  state_n = S_CHECK;
      S_CHECK: begin
        if (reg_rdata_i == step.code) state_n = step.last ? S_STOP : S_ISSUE;
        else                          state_n = S_STOP;
      end
      S_STOP:    state_n = S_P_STOP;
      S_P_STOP:  if (cond_met) state_n = S_P_IDLE; else if (expire) state_n = S_DONE;
      S_P_IDLE:  if (cond_met) state_n = S_P_LINE; else if (expire) state_n = S_DONE;
      S_P_LINE:  if (cond_met || expire) state_n = S_DONE;
      S_DONE:    state_n = S_IDLE;
      default:   state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rd_q    <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      wd_q    <= '0;
      keep_q  <= '0;
      step_q  <= '0;
      pass_q  <= 1'b0;
      stuck_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_n;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          rd_q    <= cmd_read_i;
          dev_q   <= cmd_dev_i;
          reg_q   <= cmd_reg_i;
          wd_q    <= cmd_wdata_i;
          step_q  <= '0;
          pass_q  <= 1'b0;
          stuck_q <= 1'b0;
          rx_q    <= '0;
        end
        S_GETCTL: keep_q <= reg_rdata_i[7:6];
        S_RXDATA: rx_q <= reg_rdata_i;
        S_CHECK: if (reg_rdata_i == step.code) begin
          if (step.last) pass_q <= 1'b1;
          else           step_q <= step_q + 1'b1;
        end
        S_P_STOP, S_P_IDLE, S_P_LINE: if (expire) stuck_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign pass_o      = pass_q;
  assign bus_stuck_o = stuck_q;
  assign rdata_o     = rx_q;

endmodule

// File: rtl/i2c_regseq_chk.sv
module i2c_regseq_chk #(
  parameter int unsigned POLL_LIMIT = 'h2FF
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       done_o,
  input logic       pass_o,
  input logic       bus_stuck_o,
  input logic [7:0] rdata_o,
  input logic       reg_req_o,
  input logic       reg_we_o,
  input logic [1:0] reg_addr_o,
  input logic [7:0] reg_wdata_o
);

  localparam int unsigned RW = $clog2(POLL_LIMIT + 2);

  logic          stop_seen, past_ok, prev_rd;
  logic [1:0]    prev_addr;
  logic [RW-1:0] rd_run;
  logic          ctl_wr;

  assign ctl_wr = reg_req_o && reg_we_o && (reg_addr_o == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_seen <= 1'b0;
      past_ok   <= 1'b0;
      prev_rd   <= 1'b0;
      prev_addr <= '0;
      rd_run    <= '0;
    end else begin
      past_ok <= 1'b1;
      if (cmd_valid_i && cmd_ready_o)                   stop_seen <= 1'b0;
      else if (ctl_wr && reg_wdata_o[4] && reg_wdata_o[3]) stop_seen <= 1'b1;
      prev_rd   <= reg_req_o && !reg_we_o;
      prev_addr <= reg_addr_o;
      if (reg_req_o && !reg_we_o) begin
        if (prev_rd && prev_addr == reg_addr_o) rd_run <= rd_run + 1'b1;
        else                                    rd_run <= RW'(1);
      end else begin
        rd_run <= '0;
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !reg_req_o);

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && cmd_ready_o);

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && cmd_ready_o && $past(cmd_ready_o) && !$past(cmd_valid_i)
      |-> $stable(pass_o) && $stable(bus_stuck_o) && $stable(rdata_o));

  assert_stop_before_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> stop_seen);

  assert_no_start_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |-> !(reg_wdata_o[5] && reg_wdata_o[4]));

  assert_poll_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_run <= RW'(POLL_LIMIT));

endmodule

bind i2c_regseq i2c_regseq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .bus_stuck_o (bus_stuck_o),
  .rdata_o     (rdata_o),
  .reg_req_o   (reg_req_o),
  .reg_we_o    (reg_we_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o)
);

// File: tb/tb_i2c_regseq.sv
`timescale 1ns/1ps
module tb_i2c_regseq;

  localparam int LIMIT = 767;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_dev = '0;
  logic [7:0] cmd_reg = '0, cmd_wd = '0;
  logic       cmd_ready, done, pass, stuck;
  logic [7:0] rdata;
  logic       req, we;
  logic [1:0] addr;
  logic [7:0] wdata, rdat;

  i2c_regseq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_read_i(cmd_read), .cmd_dev_i(cmd_dev), .cmd_reg_i(cmd_reg), .cmd_wdata_i(cmd_wd),
    .done_o(done), .pass_o(pass), .bus_stuck_o(stuck), .rdata_o(rdata),
    .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdat)
  );

  // scenario configuration (written by the stimulus block only)
  int         sc_gen = 0;
  logic [1:0] sc_hi = 2'b11;
  logic [7:0] sc_stat0 = 8'hF8, sc_line = 8'h3A, sc_rx = 8'h00;
  logic [7:0] sc_codes [0:7];
  int         sc_ncodes = 0;
  logic [9:0] exp_w [0:15];
  int         exp_n = 0;
  string      exp_tag = "R1";

  // controller model
  int         m_gen, m_idx, m_cnt, m_scnt;
  logic [1:0] m_hi;
  logic       m_flag, m_stop;
  logic [7:0] m_stat, m_line, m_rx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gen <= 0; m_idx <= 0; m_cnt <= 0; m_scnt <= 0; m_hi <= 2'b11;
      m_flag <= 1'b0; m_stop <= 1'b0; m_stat <= 8'hF8; m_line <= 8'h3A; m_rx <= 8'h00;
    end else if (sc_gen != m_gen) begin
      m_gen <= sc_gen; m_idx <= 0; m_cnt <= 0; m_scnt <= 0; m_hi <= sc_hi;
      m_flag <= 1'b0; m_stop <= 1'b0; m_stat <= sc_stat0; m_line <= 8'h3A; m_rx <= sc_rx;
    end else if (req && we && addr == 2'd0) begin
      m_hi <= wdata[7:6];
      if (wdata[4]) begin
        m_flag <= 1'b0; m_stop <= 1'b1; m_scnt <= 3; m_line <= 8'h3E;
      end else if (wdata[5] || wdata[3]) begin
        m_flag <= 1'b0; m_cnt <= 2;
      end
    end else begin
      if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1 && m_idx < sc_ncodes) begin
          m_flag <= 1'b1; m_stat <= sc_codes[m_idx]; m_idx <= m_idx + 1;
        end
      end
      if (m_scnt > 0) begin
        m_scnt <= m_scnt - 1;
        if (m_scnt == 1) begin
          m_stop <= 1'b0; m_stat <= 8'hF8; m_line <= sc_line;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdat = {m_hi, 1'b0, m_stop, m_flag, 3'b000};
      2'd1:    rdat = m_rx;
      2'd2:    rdat = m_stat;
      default: rdat = m_line;
    endcase
  end

  // per-clock monitor of the register port against the expected write list
  int mon_gen = 0, mon_err = 0, mon_chk = 0, w_idx = 0;
  int ctl_run = 0, stop_run = 0, line_rd = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sc_gen != mon_gen) begin
        mon_gen = sc_gen; w_idx = 0; ctl_run = 0; stop_run = 0; line_rd = 0; done_cnt = 0;
      end
      if (req && we) begin
        mon_chk++;
        if (w_idx >= exp_n || exp_w[w_idx] !== {addr, wdata}) begin
          mon_err++;
          $display("FAIL %s write #%0d: actual sel=%0d data=%h expected %h",
                   exp_tag, w_idx, addr, wdata, (w_idx < exp_n) ? exp_w[w_idx] : 10'h3FF);
        end
        w_idx++;
        if (addr == 2'd0) begin
          if (wdata[4]) stop_run = ctl_run;
          ctl_run = 0;
        end
      end else if (req) begin
        if (addr == 2'd0) ctl_run++;
        if (addr == 2'd3) line_rd++;
      end
      if (done) done_cnt++;
    end
  end

  int errors = 0, checks = 0;
  logic r_pass, r_stuck;
  logic [7:0] r_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic setup(input string tag, input logic [1:0] hi, input logic [7:0] st0,
                       input logic [7:0] line, input logic [7:0] rx);
    @(negedge clk); #0.5;
    exp_tag = tag; sc_hi = hi; sc_stat0 = st0; sc_line = line; sc_rx = rx;
    sc_ncodes = 0; exp_n = 0;
  endtask

  task automatic code(input logic [7:0] c);
    sc_codes[sc_ncodes] = c; sc_ncodes++;
  endtask

  task automatic ew(input logic [1:0] a, input logic [7:0] d);
    exp_w[exp_n] = {a, d}; exp_n++;
  endtask

  task automatic commit();
    sc_gen++;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic rd, input logic [6:0] dev, input logic [7:0] rg,
                     input logic [7:0] wd, input bit noise);
    bit seen;
    chk({exp_tag, " ready before command R2"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_read = rd; cmd_dev = dev; cmd_reg = rg; cmd_wd = wd;
    @(negedge clk);
    if (noise) begin
      cmd_read = ~rd; cmd_dev = 7'h11; cmd_reg = 8'hEE; cmd_wd = 8'h99;
      repeat (10) @(negedge clk);
    end
    cmd_valid = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      if (done) begin
        seen = 1'b1; r_pass = pass; r_stuck = stuck; r_rd = rdata;
      end else @(negedge clk);
    end
    chk({exp_tag, " done arrives R11"}, seen, 1);
    @(negedge clk);
    chk({exp_tag, " done one cycle then ready R11"}, {done, cmd_ready}, 2'b01);
    repeat (20) @(negedge clk);
    chk({exp_tag, " results held R11"}, {pass, stuck, rdata}, {r_pass, r_stuck, r_rd});
    chk({exp_tag, " all writes issued R9"}, w_idx, exp_n);
    chk({exp_tag, " single done R2"}, done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors + mon_err + 1, checks + mon_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset ready/done/req R1", {cmd_ready, done, req, pass, stuck}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("after reset R1", {cmd_ready, done, req, pass, stuck}, 5'b10000);

    // write success, bits 7:6 = 11
    setup("R4 write", 2'b11, 8'hF8, 8'h3A, 8'h00);
    code(8'h08); code(8'h18); code(8'h28); code(8'h28);
    ew(0, 8'hE0); ew(1, 8'hA0); ew(0, 8'hC8); ew(1, 8'h12); ew(0, 8'hC8);
    ew(1, 8'h3C); ew(0, 8'hC8); ew(0, 8'hD8);
    commit();
    run(1'b0, 7'h50, 8'h12, 8'h3C, 1'b0);
    chk("R4 write pass", {r_pass, r_stuck}, 2'b10);

    // read success, address byte R6
    setup("R5 read", 2'b11, 8'hF8, 8'h3A, 8'h5A);
    code(8'h08); code(8'h18); code(8'h28); code(8'h10); code(8'h40); code(8'h58);
    ew(0, 8'hE0); ew(1, 8'h56); ew(0, 8'hC8); ew(1, 8'h07); ew(0, 8'hC8);
    ew(0, 8'hE8); ew(1, 8'h57); ew(0, 8'hC8); ew(0, 8'hC8); ew(0, 8'hD8);
    commit();
    run(1'b1, 7'h2B, 8'h07, 8'h00, 1'b0);
    chk("R5 read pass", {r_pass, r_stuck}, 2'b10);
    chk("R5 read byte", r_rd, 8'h5A);

    // NACK on address with bits 7:6 = 01 (R7 preservation)
    setup("R7 nack", 2'b01, 8'hF8, 8'h3A, 8'h77);
    code(8'h08); code(8'h20);
    ew(0, 8'h60); ew(1, 8'h56); ew(0, 8'h48); ew(0, 8'h58);
    commit();
    run(1'b1, 7'h2B, 8'h07, 8'h00, 1'b0);
    chk("R7 nack fails", {r_pass, r_stuck}, 2'b00);

    // controller not idle at start
    setup("R3 busy ctrl", 2'b11, 8'h20, 8'h3A, 8'h00);
    ew(0, 8'hD8);
    commit();
    run(1'b0, 7'h50, 8'h12, 8'h3C, 1'b0);
    chk("R3 refused", {r_pass, r_stuck}, 2'b00);

    // flag never rises after address phase
    setup("R8 timeout", 2'b11, 8'hF8, 8'h3A, 8'h00);
    code(8'h08);
    ew(0, 8'hE0); ew(1, 8'hA0); ew(0, 8'hC8); ew(0, 8'hD8);
    commit();
    run(1'b0, 7'h50, 8'h12, 8'h3C, 1'b0);
    chk("R8 timeout fails", {r_pass, r_stuck}, 2'b00);
    chk("R8 poll count", stop_run, LIMIT);

    // line never returns to free after STOP
    setup("R10 stuck", 2'b11, 8'hF8, 8'h00, 8'h00);
    code(8'h08); code(8'h18); code(8'h28); code(8'h28);
    ew(0, 8'hE0); ew(1, 8'hA0); ew(0, 8'hC8); ew(1, 8'h12); ew(0, 8'hC8);
    ew(1, 8'h3C); ew(0, 8'hC8); ew(0, 8'hD8);
    commit();
    run(1'b0, 7'h50, 8'h12, 8'h3C, 1'b0);
    chk("R10 pass kept, stuck set", {r_pass, r_stuck}, 2'b11);
    chk("R10 line poll count", line_rd, LIMIT);

    // command inputs changed and re-requested while busy
    setup("R2 busy ignore", 2'b11, 8'hF8, 8'h3A, 8'h00);
    code(8'h08); code(8'h18); code(8'h28); code(8'h28);
    ew(0, 8'hE0); ew(1, 8'h84); ew(0, 8'hC8); ew(1, 8'hF0); ew(0, 8'hC8);
    ew(1, 8'h5A); ew(0, 8'hC8); ew(0, 8'hD8);
    commit();
    run(1'b0, 7'h42, 8'hF0, 8'h5A, 1'b1);
    chk("R2 latched write pass", {r_pass, r_stuck}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors + mon_err, checks + mon_chk);
    $finish;
  end

endmodule